// File: doc/BRIEF.md
# Three-Bridge Serial Switch Controller

This block is the digital front end of a driver for three half-bridges, each built from a low-side and a high-side switch. A host talks to it over a 16-bit serial slave link. While chip select is low, a command word enters least significant bit first on the data input, and a status word leaves least significant bit first on the data output. The command takes effect only when chip select returns high, and only if exactly sixteen bits were clocked in. Otherwise the previous command stays in force.

The committed command sets six switch enables, and per-switch bits can also let each switch follow an external PWM input. The command also carries a software inhibit (standby), an open-load detection enable with active-low polarity, and an overcurrent shutdown enable. Two fault inputs, overload and supply fault, are latched into sticky flags. A command with its lowest bit set clears those flags. The status word is a snapshot taken when chip select falls. It carries the flags, the per-switch feedback inputs and a fault summary bit.

All serial pins are sampled with the system clock through synchronizers. The serial clock must therefore run well below the system clock: each serial clock phase should last several system clock cycles.

Top module: `hbr_spi_ctrl`

## Requirements
- R1: A command word is applied to the outputs only after chip select rises. Before that, a transfer in progress leaves every output unchanged.
- R2: Both words travel least significant bit first. Input bits are sampled on falling serial clock edges. Output bit k is valid from the k-th rising serial clock edge (bit 0 from the chip select fall) until the next rising edge.
- R3: `spi_miso_oe` is 0 whenever chip select is high and 1 during a transfer. The status word is captured at the chip select fall.
- R4: Command bits 1..6 switch on, in this order, bridge 1 low, bridge 1 high, bridge 2 low, bridge 2 high, bridge 3 low and bridge 3 high. These map to `drv_sw[0]`..`drv_sw[5]`, and 1 means on.
- R5: Command bits 7..12 are PWM enables in the same switch order. When an enable is set, its switch is also on while `pwm_in` is 1.
- R6: Command bit 15 is the inhibit bit, where 0 means standby. In standby all `drv_sw` are 0 and `standby` is 1, while serial transfers and status readout keep working.
- R7: `ol_en` equals the inverse of command bit 13, and `oc_en` equals command bit 14.
- R8: If both switches of one bridge would be on, both are driven off.
- R9: A frame that ends after any number of falling serial clock edges other than 16 is discarded, and the previous command is kept.
- R10: The overload and supply-fault flags are set by their inputs and stay set after the input drops. A committed command with bit 0 set clears them, unless the input is still high in the commit cycle, in which case the flag stays set.
- R11: The status word has bit 0 = overload flag OR supply-fault flag, bits 1..6 = `sw_fb[0..5]`, bit 13 = overload flag and bit 15 = supply-fault flag. All other bits are 0.
- R12: After reset the command is all zeros: drives off, `standby`=1, `ol_en`=1, `oc_en`=0 and `spi_miso_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial command data |
| spi_miso | output | 1 | Serial status data |
| spi_miso_oe | output | 1 | Output enable for the data-out pad driver |
| pwm_in | input | 1 | External PWM input |
| sw_fb | input | 6 | Per-switch feedback, in switch order |
| ovl_in | input | 1 | Overload fault input |
| psf_in | input | 1 | Supply fault input |
| drv_sw | output | 6 | Switch drives, in switch order |
| standby | output | 1 | 1 while software inhibit is active |
| ol_en | output | 1 | Open-load detection enable |
| oc_en | output | 1 | Overcurrent shutdown enable |

## Verification
Two events can land in the same cycle: a fault input being high, and the commit of a command that clears the sticky flags. The bench holds the supply-fault input high across a clearing transfer and drops it only after the commit. The next status word must still show the flag set. Under the same conditions, the overload flag, which was pulsed earlier and is low at commit, must read back as cleared. The sweeps also combine direct bits with PWM enables so that the PWM path and the shoot-through guard act together, and the expected drive vector is computed from the bit rules.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
    localparam int BRIDGES = 3;
    localparam int SW      = 2 * BRIDGES;
    localparam int WORD_W  = 16;
    localparam int CNT_W   = $clog2(WORD_W + 1);

    // status word positions
    localparam int ST_SUM = 0;
    localparam int ST_FB0 = 1;
    localparam int ST_OVL = 13;
    localparam int ST_PSF = 15;

    // command word, MSB first: inhibit, ocs enable, open-load (active low), pwm enables, direct, clear
    typedef struct packed {
        logic          inh;
        logic          ocs;
        logic          old_n;
        logic [SW-1:0] pwm_en;
        logic [SW-1:0] dir;
        logic          clr;
    } cmd_t;

    typedef struct packed {
        logic              sclk_p;
        logic              csn_p;
        logic [WORD_W-1:0] rx_sh;
        logic [WORD_W-1:0] tx_sh;
        logic [WORD_W-1:0] rx_word;
        logic [CNT_W-1:0]  cnt;
        logic              rise_seen;
        logic              oe;
        logic              done;
    } spi_state_t;

    typedef struct packed {
        cmd_t          cmd;
        logic [SW-1:0] drv;
        logic          ovl_f;
        logic          psf_f;
    } drv_state_t;
endpackage

// File: rtl/hbr_sync.sv
module hbr_sync #(
    parameter int             W      = 1,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                st_q[i] <= RST;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/hbr_spi_shift.sv
module hbr_spi_shift
    import hbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              mosi_s,
    input  logic [WORD_W-1:0] status_word,
    output logic [WORD_W-1:0] rx_word,
    output logic              word_ok,
    output logic              miso,
    output logic              miso_oe
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    spi_state_t q, d;
    logic sclk_fall, sclk_rise, cs_fall, cs_rise, active;

    always_comb begin
        sclk_fall = q.sclk_p & ~sclk_s;
        sclk_rise = ~q.sclk_p & sclk_s;
        cs_fall   = q.csn_p & ~csn_s;
        cs_rise   = ~q.csn_p & csn_s;
        active    = ~q.csn_p & ~csn_s;

        d        = q;
        d.sclk_p = sclk_s;
        d.csn_p  = csn_s;
        d.done   = 1'b0;

        if (cs_fall) begin
            d.tx_sh     = status_word;
            d.cnt       = '0;
            d.rise_seen = 1'b0;
            d.oe        = 1'b1;
        end else if (active) begin
            if (sclk_fall) begin
                d.rx_sh = {mosi_s, q.rx_sh[WORD_W-1:1]};
                if (q.cnt != '1) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            if (sclk_rise) begin
                if (q.rise_seen) begin
                    d.tx_sh = {1'b0, q.tx_sh[WORD_W-1:1]};
                end
                d.rise_seen = 1'b1;
            end
        end

        if (cs_rise) begin
            d.oe = 1'b0;
            if (q.cnt == FULL) begin
                d.done    = 1'b1;
                d.rx_word = q.rx_sh;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.csn_p  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_word = q.rx_word;
    assign word_ok = q.done;
    assign miso    = q.tx_sh[0];
    assign miso_oe = q.oe;

    AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.csn_p && csn_s) |=> !q.oe); // R3
    AST_BAD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && q.cnt != FULL) |=> !q.done); // R9
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !q.done |-> $stable(q.rx_word)); // R1
    AST_DONE_ONLY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> q.csn_p); // R1
endmodule

// File: rtl/hbr_drive.sv
module hbr_drive
    import hbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              cmd_load,
    input  logic              pwm_s,
    input  logic [SW-1:0]     fb_s,
    input  logic              ovl_s,
    input  logic              psf_s,
    output logic [SW-1:0]     drv,
    output logic              standby,
    output logic              ol_en,
    output logic              oc_en,
    output logic [WORD_W-1:0] status_word
);
    drv_state_t q, d;
    cmd_t       new_cmd;
    logic       clr_now;
    logic [SW-1:0] raw;

    always_comb begin
        new_cmd = cmd_t'(cmd_word);
        clr_now = cmd_load & new_cmd.clr;

        d = q;
        if (cmd_load) begin
            d.cmd = new_cmd;
        end
        // a fault present in the commit cycle wins over the clear
        d.ovl_f = ovl_s | (q.ovl_f & ~clr_now);
        d.psf_f = psf_s | (q.psf_f & ~clr_now);

        raw = (q.cmd.dir | (q.cmd.pwm_en & {SW{pwm_s}})) & {SW{q.cmd.inh}};
        for (int b = 0; b < BRIDGES; b++) begin
            if (raw[2*b] && raw[2*b+1]) begin
                d.drv[2*b]   = 1'b0;
                d.drv[2*b+1] = 1'b0;
            end else begin
                d.drv[2*b]   = raw[2*b];
                d.drv[2*b+1] = raw[2*b+1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        status_word                    = '0;
        status_word[ST_SUM]            = q.ovl_f | q.psf_f;
        status_word[ST_FB0 +: SW]      = fb_s;
        status_word[ST_OVL]            = q.ovl_f;
        status_word[ST_PSF]            = q.psf_f;
    end

    assign drv     = q.drv;
    assign standby = ~q.cmd.inh;
    assign ol_en   = ~q.cmd.old_n;
    assign oc_en   = q.cmd.ocs;

    genvar gb;
    generate
        for (gb = 0; gb < BRIDGES; gb++) begin : g_guard
            AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
                !(q.drv[2*gb] && q.drv[2*gb+1])); // R8
        end
    endgenerate

    AST_INH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !q.cmd.inh |=> (q.drv == '0)); // R6
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_load |=> $stable(q.cmd)); // R1
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovl_f && !cmd_load) |=> q.ovl_f); // R10
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && cmd_word[0] && !psf_s) |=> !q.psf_f); // R10
endmodule

// File: rtl/hbr_spi_ctrl.sv
module hbr_spi_ctrl
    import hbr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_csn,
    input  logic          spi_sclk,
    input  logic          spi_mosi,
    output logic          spi_miso,
    output logic          spi_miso_oe,
    input  logic          pwm_in,
    input  logic [SW-1:0] sw_fb,
    input  logic          ovl_in,
    input  logic          psf_in,
    output logic [SW-1:0] drv_sw,
    output logic          standby,
    output logic          ol_en,
    output logic          oc_en
);
    localparam int VW = SW + 5;

    logic          csn_s;
    logic [VW-1:0] vec_s;
    logic [WORD_W-1:0] rx_word, status_word;
    logic          word_ok;

    hbr_sync #(.W(1), .STAGES(SYNC_STAGES), .RST(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .d(spi_csn), .q(csn_s)
    );

    hbr_sync #(.W(VW), .STAGES(SYNC_STAGES), .RST('0)) u_sync_vec (
        .clk(clk), .rst_n(rst_n),
        .d({spi_sclk, spi_mosi, pwm_in, sw_fb, ovl_in, psf_in}),
        .q(vec_s)
    );

    hbr_spi_shift u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(vec_s[VW-1]), .csn_s(csn_s), .mosi_s(vec_s[VW-2]),
        .status_word(status_word),
        .rx_word(rx_word), .word_ok(word_ok),
        .miso(spi_miso), .miso_oe(spi_miso_oe)
    );

    hbr_drive u_drive (
        .clk(clk), .rst_n(rst_n),
        .cmd_word(rx_word), .cmd_load(word_ok),
        .pwm_s(vec_s[VW-3]), .fb_s(vec_s[2 +: SW]),
        .ovl_s(vec_s[1]), .psf_s(vec_s[0]),
        .drv(drv_sw), .standby(standby), .ol_en(ol_en), .oc_en(oc_en),
        .status_word(status_word)
    );
endmodule

// File: tb/hbr_spi_ctrl_test.sv
`timescale 1ns/1ps
module hbr_spi_ctrl_test;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_csn = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe;
    logic pwm_in = 1'b0;
    logic [5:0] sw_fb = '0;
    logic ovl_in = 1'b0, psf_in = 1'b0;
    logic [5:0] drv_sw;
    logic standby, ol_en, oc_en;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    hbr_spi_ctrl uut (
        .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .pwm_in(pwm_in), .sw_fb(sw_fb), .ovl_in(ovl_in), .psf_in(psf_in),
        .drv_sw(drv_sw), .standby(standby), .ol_en(ol_en), .oc_en(oc_en)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bits per transfer; returns received status bits (LSB first)
    task automatic xfer(input logic [31:0] tx, input int nbits,
                        output logic [15:0] rx);
        rx = '0;
        spi_csn = 1'b0;
        wait_n(H);
        for (int i = 0; i < nbits; i++) begin
            spi_sclk = 1'b1;
            spi_mosi = tx[i];
            wait_n(H);
            if (i < 16) rx[i] = spi_miso;
            if (i == 8) check("R3", "oe during frame", {31'd0, spi_miso_oe}, 32'd1);
            spi_sclk = 1'b0;
            wait_n(H);
        end
        spi_csn = 1'b1;
        wait_n(12);
    endtask

    function automatic logic [5:0] exp_drv(logic [5:0] dir, logic [5:0] en,
                                           logic pwm, logic inh);
        logic [5:0] r;
        r = (dir | (en & {6{pwm}})) & {6{inh}};
        for (int b = 0; b < 3; b++) begin
            if (r[2*b] && r[2*b+1]) begin
                r[2*b] = 1'b0;
                r[2*b+1] = 1'b0;
            end
        end
        return r;
    endfunction

    function automatic logic [15:0] exp_stat(logic [5:0] fb, logic ovl, logic psf);
        logic [15:0] s;
        s = '0;
        s[0] = ovl | psf;
        s[6:1] = fb;
        s[13] = ovl;
        s[15] = psf;
        return s;
    endfunction

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        report();
    end

    initial begin
        logic [15:0] rx;
        logic [5:0]  keep;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(5);

        // R12 reset state
        check("R12", "drv", {26'd0, drv_sw}, 32'd0);
        check("R12", "standby", {31'd0, standby}, 32'd1);
        check("R12", "ol_en", {31'd0, ol_en}, 32'd1);
        check("R12", "oc_en", {31'd0, oc_en}, 32'd0);
        check("R3", "oe idle", {31'd0, spi_miso_oe}, 32'd0);

        // R4 R8 R2: sweep of all direct patterns, inhibit off
        for (int p = 0; p < 64; p++) begin
            xfer(32'h8000 | (p << 1), 16, rx);
            check("R4", "direct drive", {26'd0, drv_sw},
                  {26'd0, exp_drv(6'(p), 6'd0, 1'b0, 1'b1)});
        end
        check("R3", "oe after frame", {31'd0, spi_miso_oe}, 32'd0);

        // R5 R8: sweep of PWM enables, both PWM levels
        for (int e = 0; e < 64; e++) begin
            pwm_in = 1'b0;
            xfer(32'h8000 | (e << 7) | (32'h2 << 1), 16, rx);
            check("R5", "pwm low", {26'd0, drv_sw},
                  {26'd0, exp_drv(6'd2, 6'(e), 1'b0, 1'b1)});
            pwm_in = 1'b1;
            wait_n(6);
            check("R5", "pwm high", {26'd0, drv_sw},
                  {26'd0, exp_drv(6'd2, 6'(e), 1'b1, 1'b1)});
        end
        pwm_in = 1'b0;

        // R7 control bits
        xfer(32'hE000, 16, rx);
        check("R7", "ol_en off", {31'd0, ol_en}, 32'd0);
        check("R7", "oc_en on", {31'd0, oc_en}, 32'd1);
        xfer(32'h8000, 16, rx);
        check("R7", "ol_en on", {31'd0, ol_en}, 32'd1);
        check("R7", "oc_en off", {31'd0, oc_en}, 32'd0);

        // R9 / R1: good frame, then short and long frames are dropped
        xfer(32'h8000 | (6'b100101 << 1), 16, rx);
        keep = drv_sw;
        check("R1", "applied", {26'd0, keep}, 32'b100101);
        xfer(32'h8000 | (6'b011010 << 1), 15, rx);
        check("R9", "short frame", {26'd0, drv_sw}, {26'd0, keep});
        xfer(32'h8000 | (6'b011010 << 1), 17, rx);
        check("R9", "long frame", {26'd0, drv_sw}, {26'd0, keep});

        // R6 standby: drives off, readout still works
        sw_fb = 6'b110010;
        wait_n(6);
        xfer(32'h0000 | (6'b010101 << 1), 16, rx);
        check("R6", "standby drv", {26'd0, drv_sw}, 32'd0);
        check("R6", "standby pin", {31'd0, standby}, 32'd1);
        xfer(32'h0000 | (6'b010101 << 1), 16, rx);
        check("R6", "readout in standby", {16'd0, rx},
              {16'd0, exp_stat(6'b110010, 1'b0, 1'b0)});

        // R10 R11: overload pulse, sticky, clear
        sw_fb = 6'b011001;
        ovl_in = 1'b1;
        wait_n(6);
        ovl_in = 1'b0;
        wait_n(6);
        xfer(32'h8000, 16, rx);
        check("R11", "status with ovl", {16'd0, rx},
              {16'd0, exp_stat(6'b011001, 1'b1, 1'b0)});
        xfer(32'h8001, 16, rx);
        check("R10", "sticky before clear", {16'd0, rx},
              {16'd0, exp_stat(6'b011001, 1'b1, 1'b0)});
        xfer(32'h8000, 16, rx);
        check("R10", "cleared", {16'd0, rx},
              {16'd0, exp_stat(6'b011001, 1'b0, 1'b0)});

        // R10 clear while supply fault still high: flag stays set
        psf_in = 1'b1;
        ovl_in = 1'b1;
        wait_n(6);
        ovl_in = 1'b0;
        wait_n(6);
        xfer(32'h8001, 16, rx);
        check("R11", "both flags", {16'd0, rx},
              {16'd0, exp_stat(6'b011001, 1'b1, 1'b1)});
        psf_in = 1'b0;
        wait_n(6);
        xfer(32'h8000, 16, rx);
        check("R10", "fault wins over clear", {16'd0, rx},
              {16'd0, exp_stat(6'b011001, 1'b0, 1'b1)});
        xfer(32'h8001, 16, rx);
        xfer(32'h8000, 16, rx);
        check("R10", "psf cleared", {16'd0, rx},
              {16'd0, exp_stat(6'b011001, 1'b0, 1'b0)});

        // R2 asymmetric feedback pattern read LSB first
        sw_fb = 6'b000001;
        wait_n(6);
        xfer(32'h8000, 16, rx);
        check("R2", "lsb first status", {16'd0, rx}, 32'h0002);

        report();
    end
endmodule